// File: doc/BRIEF.md
# Two-Level Nested Vectored Interrupt Controller

This block gathers seven interrupt sources for an 8-bit processor core: two external pins, timers 0, 1 and 2, a serial port and an I2C unit. Each source has its own enable bit, and a master enable gates all of them. Each source also carries one priority bit that places it at high or low level. Among the eligible requests the block picks a winner and offers its vector address to the CPU on a registered request/vector pair. The CPU takes the vector with an acknowledge strobe and ends the handler with a return strobe. Two in-service flags record which levels are active, so a high-level request can interrupt a low-level handler. A low-level request can never interrupt a high-level one.

Each external pin is active low and passes through a synchronizer. In edge mode a falling edge sets a sticky flag, and that flag clears when its vector is acknowledged. In level mode the request follows the synchronized pin. The block also makes a wake signal for the sleep controller. In power-down, only a level-mode external pin that is enabled and held low wakes the device. In idle, any eligible request wakes it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During and after a synchronous reset, irq_o, vec_o and wake_o are 0, and all enable and priority bits are 0, so no request is presented until configuration is written.
- R2: A write with cfg_sel_i=0 loads the enable register. Bit 7 is the master enable. Bits 0..6 enable ext0, timer0, ext1, timer1, serial, timer2 and I2C respectively. A request is eligible only when its own bit and bit 7 are both 1.
- R3: A write with cfg_sel_i=1 loads the priority register, using the same bit-to-source mapping (1 = high level). Bit 7 is ignored.
- R4: The presented vector is 0x0003 for ext0, 0x000B for timer0, 0x0013 for ext1, 0x001B for timer1, 0x0023 for serial, 0x002B for timer2 and 0x0053 for I2C.
- R5: Within one level the winner follows this order, first to last: ext0, timer2, I2C, timer0, ext1, timer1, serial.
- R6: An eligible high-level request always beats every low-level request, regardless of the polling order.
- R7: An acknowledge sets the in-service flag of the presented source's level. While the high flag is set nothing is presented. While only the low flag is set, only high-level requests are presented. reti_i clears the high flag if it is set, and otherwise clears the low flag.
- R8: irq_o and vec_o change one clock after their causes. In the clock after an accepted acknowledge (ack_i with irq_o high), irq_o is 0.
- R9: In edge mode (ext_edge_i bit = 1), a falling edge on the pin sets a request flag that stays set after the pin rises, and an acknowledge of that source clears it. If a new falling edge is detected in the same cycle as the acknowledge, the flag stays set.
- R10: In level mode (ext_edge_i bit = 0), the external request equals the inverted pin after SYNC_STAGES clocks and is never latched.
- R11: With pdown_i high, wake_o goes to 1 only for an external pin that is in level mode, enabled (own bit and bit 7) and held low. Timer requests and edge-mode pins do not wake the device.
- R12: With idle_i high, wake_o goes to 1 one clock after any request becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n_i | input | 2 | External request pins, active low (bit 0 = ext0, bit 1 = ext1) |
| ext_edge_i | input | 2 | Per-pin trigger mode: 1 = falling edge, 0 = low level |
| periph_req_i | input | 5 | On-chip requests: [0] timer0, [1] timer1, [2] serial, [3] timer2, [4] I2C |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = enable register, 1 = priority register |
| cfg_wdata_i | input | 8 | Configuration write data |
| ack_i | input | 1 | CPU takes the presented vector |
| reti_i | input | 1 | CPU returns from the current handler |
| idle_i | input | 1 | Device is in idle |
| pdown_i | input | 1 | Device is in power-down |
| irq_o | output | 1 | Interrupt request to the CPU (registered) |
| vec_o | output | 16 | Vector address of the presented source (registered) |
| wake_o | output | 1 | Wake request for the sleep controller (registered) |

## Verification
The delicate coincidence is an acknowledge that clears an external edge flag in the same cycle as a fresh falling edge on that pin is detected. The bench sets this up on ext0 in edge mode. It raises the pin, then lowers it again, and places ack_i exactly SYNC_STAGES clocks after the new low level was driven, so the synchronized fall and the acknowledge meet at one clock edge. The outcome is judged at the ports. The request must stay absent while the low level is in service, and after reti_i the vector 0x0003 must return, which shows the new edge was kept.

// File: rtl/prio_irq_ctrl_pkg.sv
package prio_irq_ctrl_pkg;

  localparam int NSRC  = 7;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 16;

  // source index equals its bit position in the enable and priority registers
  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_UART = 3'd4,
    SRC_TMR2 = 3'd5,
    SRC_I2C  = 3'd6
  } src_e;

  function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
    case (idx)
      SRC_EXT0: src_vector = 16'h0003;
      SRC_TMR0: src_vector = 16'h000B;
      SRC_EXT1: src_vector = 16'h0013;
      SRC_TMR1: src_vector = 16'h001B;
      SRC_UART: src_vector = 16'h0023;
      SRC_TMR2: src_vector = 16'h002B;
      SRC_I2C:  src_vector = 16'h0053;
      default:  src_vector = 16'h0003;
    endcase
  endfunction

  // rank 0 is polled first
  function automatic logic [IDX_W-1:0] poll_src(input int rank);
    case (rank)
      0:       poll_src = SRC_EXT0;
      1:       poll_src = SRC_TMR2;
      2:       poll_src = SRC_I2C;
      3:       poll_src = SRC_TMR0;
      4:       poll_src = SRC_EXT1;
      5:       poll_src = SRC_TMR1;
      default: poll_src = SRC_UART;
    endcase
  endfunction

endpackage

// File: rtl/irq_ext_capture.sv
module irq_ext_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req,
  output logic lvl_active
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   pin_s;
  logic                   fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= pin_s;
    end
  end

  // a fresh fall outranks the acknowledge clear
  always_ff @(posedge clk) begin
    if (rst || !edge_mode) flag_q <= 1'b0;
    else if (fall)         flag_q <= 1'b1;
    else if (clr)          flag_q <= 1'b0;
  end

  assign lvl_active = ~pin_s;
  assign req        = edge_mode ? flag_q : ~pin_s;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_ctrl_pkg::*;
(
  input  logic [NSRC-1:0]  elig,
  input  logic [NSRC-1:0]  pri,
  input  logic             ins_hi,
  input  logic             ins_lo,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);

  logic [NSRC-1:0]  hi_cand;
  logic [NSRC-1:0]  lo_cand;
  logic [IDX_W-1:0] hi_idx;
  logic [IDX_W-1:0] lo_idx;

  assign hi_cand = elig & pri;
  assign lo_cand = elig & ~pri;

  // walk ranks from last to first so the earliest-polled source wins
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (hi_cand[poll_src(r)]) hi_idx = poll_src(r);
      if (lo_cand[poll_src(r)]) lo_idx = poll_src(r);
    end
  end

  always_comb begin
    valid = 1'b0;
    idx   = lo_idx;
    hi    = 1'b0;
    if (!ins_hi) begin
      if (|hi_cand) begin
        valid = 1'b1;
        idx   = hi_idx;
        hi    = 1'b1;
      end else if (!ins_lo && |lo_cand) begin
        valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic ins_hi,
  output logic ins_lo
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      if (reti) begin
        if (ins_hi) ins_hi <= 1'b0;
        else        ins_lo <= 1'b0;
      end
      if (take) begin
        if (take_hi) ins_hi <= 1'b1;
        else         ins_lo <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_EXT       = 2,
  parameter int N_PERIPH    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_EXT-1:0]    ext_pin_n_i,
  input  logic [N_EXT-1:0]    ext_edge_i,
  input  logic [N_PERIPH-1:0] periph_req_i,
  input  logic                cfg_we_i,
  input  logic                cfg_sel_i,
  input  logic [7:0]          cfg_wdata_i,
  input  logic                ack_i,
  input  logic                reti_i,
  input  logic                idle_i,
  input  logic                pdown_i,
  output logic                irq_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic                wake_o
);

  localparam int GEN_BIT = NSRC;

  logic [NSRC:0]      en_q;
  logic [NSRC-1:0]    pri_q;
  logic [NSRC-1:0]    pending;
  logic [NSRC-1:0]    elig;
  logic [N_EXT-1:0]   ext_req;
  logic [N_EXT-1:0]   ext_lvl;
  logic [N_EXT-1:0]   lvl_wake;
  logic               arb_valid;
  logic [IDX_W-1:0]   arb_idx;
  logic               arb_hi;
  logic               ins_hi_q;
  logic               ins_lo_q;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;
  logic [IDX_W-1:0]   pres_idx_q;
  logic               pres_hi_q;
  logic               wake_q;
  logic               take;

  assign take = ack_i & irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i) pri_q <= cfg_wdata_i[NSRC-1:0];
      else           en_q  <= cfg_wdata_i[NSRC:0];
    end
  end

  // external pins sit at register positions 0 and 2
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    localparam logic [IDX_W-1:0] SRC_IDX = (g == 0) ? SRC_EXT0 : SRC_EXT1;

    irq_ext_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk        (clk),
      .rst        (rst),
      .pin_n      (ext_pin_n_i[g]),
      .edge_mode  (ext_edge_i[g]),
      .clr        (take && (pres_idx_q == SRC_IDX)),
      .req        (ext_req[g]),
      .lvl_active (ext_lvl[g])
    );

    assign lvl_wake[g] = ext_lvl[g] & ~ext_edge_i[g] & en_q[SRC_IDX] & en_q[GEN_BIT];
  end

  assign pending = {periph_req_i[4], periph_req_i[3], periph_req_i[2],
                    periph_req_i[1], ext_req[1], periph_req_i[0], ext_req[0]};
  assign elig    = pending & en_q[NSRC-1:0] & {NSRC{en_q[GEN_BIT]}};

  irq_arbiter u_arb (
    .elig   (elig),
    .pri    (pri_q),
    .ins_hi (ins_hi_q),
    .ins_lo (ins_lo_q),
    .valid  (arb_valid),
    .idx    (arb_idx),
    .hi     (arb_hi)
  );

  irq_nest_track u_nest (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_hi (pres_hi_q),
    .reti    (reti_i),
    .ins_hi  (ins_hi_q),
    .ins_lo  (ins_lo_q)
  );

  // presentation register; an accepted acknowledge blanks one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= 1'b0;
      vec_q      <= '0;
      pres_idx_q <= '0;
      pres_hi_q  <= 1'b0;
    end else if (take) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= arb_valid;
      if (arb_valid) begin
        vec_q      <= src_vector(arb_idx);
        pres_idx_q <= arb_idx;
        pres_hi_q  <= arb_hi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= (pdown_i & |lvl_wake) | (idle_i & |elig);
  end

  assign irq_o  = irq_q;
  assign vec_o  = vec_q;
  assign wake_o = wake_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic irq,
  input logic ack,
  input logic reti,
  input logic ins_hi,
  input logic ins_lo,
  input logic pres_hi,
  input logic gen_en
);

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq);

  a_r8_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> !irq);

  a_r7_ack_sets_level: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> (ins_hi || ins_lo));

  a_r7_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
    ins_hi |-> !irq);

  a_r7_low_admits_high: assert property (@(posedge clk) disable iff (rst)
    (ins_lo && irq) |-> pres_hi);

  a_r7_reti_clears_high: assert property (@(posedge clk) disable iff (rst)
    (reti && ins_hi) |=> !ins_hi);

  a_r2_master_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(gen_en));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq     (irq_o),
  .ack     (ack_i),
  .reti    (reti_i),
  .ins_hi  (ins_hi_q),
  .ins_lo  (ins_lo_q),
  .pres_hi (pres_hi_q),
  .gen_en  (en_q[7])
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  ext_pin_n_i;
  logic [1:0]  ext_edge_i;
  logic [4:0]  periph_req_i;
  logic        cfg_we_i;
  logic        cfg_sel_i;
  logic [7:0]  cfg_wdata_i;
  logic        ack_i;
  logic        reti_i;
  logic        idle_i;
  logic        pdown_i;
  logic        irq_o;
  logic [15:0] vec_o;
  logic        wake_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .ext_pin_n_i  (ext_pin_n_i),
    .ext_edge_i   (ext_edge_i),
    .periph_req_i (periph_req_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .ack_i        (ack_i),
    .reti_i       (reti_i),
    .idle_i       (idle_i),
    .pdown_i      (pdown_i),
    .irq_o        (irq_o),
    .vec_o        (vec_o),
    .wake_o       (wake_o)
  );

  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: exp_vec = 16'h0003; 1: exp_vec = 16'h000B; 2: exp_vec = 16'h0013;
      3: exp_vec = 16'h001B; 4: exp_vec = 16'h0023; 5: exp_vec = 16'h002B;
      default: exp_vec = 16'h0053;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    ext_pin_n_i = 2'b11; ext_edge_i = 2'b00; periph_req_i = '0;
    cfg_we_i = 0; cfg_sel_i = 0; cfg_wdata_i = '0;
    ack_i = 0; reti_i = 0; idle_i = 0; pdown_i = 0;
    rst = 1; step(3); rst = 0; step(1);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d; step(1); cfg_we_i = 0;
  endtask

  task automatic pulse_ack();  ack_i = 1;  step(1); ack_i = 0;  endtask
  task automatic pulse_reti(); reti_i = 1; step(1); reti_i = 0; endtask

  // drive a source by register index (external ones via level-mode pins)
  task automatic set_src(input int s, input logic on);
    case (s)
      0: ext_pin_n_i[0] = ~on; 2: ext_pin_n_i[1] = ~on;
      1: periph_req_i[0] = on; 3: periph_req_i[1] = on; 4: periph_req_i[2] = on;
      5: periph_req_i[3] = on; default: periph_req_i[4] = on;
    endcase
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq after reset", irq_o, 0);
    check("R1 vec after reset", vec_o, 0);
    check("R1 wake after reset", wake_o, 0);
    periph_req_i = 5'h1F; idle_i = 1; step(3);
    check("R1 defaults leave requests masked", irq_o, 0);
    check("R1 defaults give no idle wake", wake_o, 0);
  endtask

  task automatic t_enable();
    do_reset();
    periph_req_i[0] = 1;
    wr(0, 8'h02); step(1);
    check("R2 source bit without master", irq_o, 0);
    wr(0, 8'h80); step(1);
    check("R2 master without source bit", irq_o, 0);
    wr(0, 8'h82); step(1);
    check("R2 both bits set", irq_o, 1);
    check("R2 timer0 vector", vec_o, 16'h000B);
  endtask

  task automatic t_vectors();
    for (int s = 0; s < 7; s++) begin
      do_reset();
      wr(0, 8'h80 | (8'h01 << s));
      set_src(s, 1); step(4);
      check($sformatf("R4 vector of source %0d", s), vec_o, exp_vec(s));
      check($sformatf("R4 irq of source %0d", s), irq_o, 1);
    end
  endtask

  task automatic t_polling();
    int order[7] = '{0, 5, 6, 1, 2, 3, 4};
    do_reset();
    wr(0, 8'hFF);
    for (int s = 0; s < 7; s++) set_src(s, 1);
    step(4);
    for (int k = 0; k < 7; k++) begin
      check($sformatf("R5 poll rank %0d", k), vec_o, exp_vec(order[k]));
      set_src(order[k], 0); step(4);
    end
    check("R5 all released", irq_o, 0);
  endtask

  task automatic t_priority();
    do_reset();
    wr(0, 8'hFF);
    wr(1, 8'h90);   // serial high; bit 7 must be ignored
    for (int s = 0; s < 7; s++) set_src(s, 1);
    step(4);
    check("R6 high serial beats ext0", vec_o, 16'h0023);
    wr(1, 8'h80); step(1);
    check("R3 priority bit7 ignored, ext0 wins", vec_o, 16'h0003);
  endtask

  task automatic t_nesting();
    do_reset();
    wr(0, 8'hFF);
    set_src(1, 1); step(1);
    check("R7 low timer0 presented", vec_o, 16'h000B);
    pulse_ack();
    check("R8 irq drops after ack", irq_o, 0);
    set_src(1, 0); set_src(3, 1); step(2);
    check("R7 low blocked by low in service", irq_o, 0);
    wr(1, 8'h40); set_src(6, 1); step(2);
    check("R7 high I2C preempts low", vec_o, 16'h0053);
    check("R7 high I2C irq", irq_o, 1);
    pulse_ack(); set_src(6, 0);
    wr(1, 8'h50); set_src(4, 1); step(2);
    check("R7 high blocks high", irq_o, 0);
    pulse_reti(); step(1);
    check("R7 reti clears high first", vec_o, 16'h0023);
    pulse_ack(); set_src(4, 0); step(1);
    pulse_reti(); step(2);
    check("R7 low still in service", irq_o, 0);
    pulse_reti(); step(1);
    check("R7 low cleared, timer1 presented", vec_o, 16'h001B);
  endtask

  task automatic t_edge();
    do_reset();
    wr(0, 8'h84); ext_edge_i[1] = 1; step(3);
    ext_pin_n_i[1] = 0; step(2); ext_pin_n_i[1] = 1; step(2);
    check("R9 edge flag held after pin rises", irq_o, 1);
    check("R9 ext1 vector", vec_o, 16'h0013);
    pulse_ack(); pulse_reti(); step(2);
    check("R9 ack clears edge flag", irq_o, 0);
  endtask

  task automatic t_collision();
    do_reset();
    wr(0, 8'h81); ext_edge_i[0] = 1; step(3);
    ext_pin_n_i[0] = 0; step(4);
    check("R9 first ext0 edge", vec_o, 16'h0003);
    ext_pin_n_i[0] = 1; step(3);
    ext_pin_n_i[0] = 0; step(2);
    pulse_ack();
    check("R8 ack accepted in collision", irq_o, 0);
    step(2);
    check("R7 low in service blocks ext0", irq_o, 0);
    pulse_reti(); step(1);
    check("R9 new edge kept despite ack", irq_o, 1);
    check("R9 kept edge vector", vec_o, 16'h0003);
  endtask

  task automatic t_level();
    do_reset();
    wr(0, 8'h84);
    ext_pin_n_i[1] = 0; step(2);
    check("R10 not yet through synchronizer", irq_o, 0);
    step(1);
    check("R10 level request", irq_o, 1);
    ext_pin_n_i[1] = 1; step(3);
    check("R10 level request not latched", irq_o, 0);
  endtask

  task automatic t_pdown_wake();
    do_reset();
    wr(0, 8'h83); pdown_i = 1;
    periph_req_i[0] = 1; step(3);
    check("R11 timer does not wake power-down", wake_o, 0);
    ext_edge_i[0] = 1; ext_pin_n_i[0] = 0; step(4);
    check("R11 edge-mode pin does not wake", wake_o, 0);
    ext_edge_i[0] = 0; step(1);
    check("R11 level-mode low pin wakes", wake_o, 1);
    ext_pin_n_i[0] = 1; step(3);
    check("R11 wake ends when pin high", wake_o, 0);
  endtask

  task automatic t_idle_wake();
    do_reset();
    idle_i = 1; wr(0, 8'h20); periph_req_i[3] = 1; step(2);
    check("R12 no wake without master", wake_o, 0);
    wr(0, 8'hA0); step(1);
    check("R12 eligible timer2 wakes idle", wake_o, 1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_vectors();
    t_polling();
    t_priority();
    t_nesting();
    t_edge();
    t_collision();
    t_level();
    t_pdown_wake();
    t_idle_wake();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule